// File: doc/BRIEF.md
# SPI Serial Clock Generator

This block derives the serial clock of an SPI master from the single system clock. A transfer engine raises a run input for as long as bits should move. While run is high the block counts system cycles through a programmed period and drives SCK to its active level for the first part of each period and back to its resting level for the remainder. Alongside SCK it emits two single-cycle strobes: one on every move to the active level, where the data path samples, and one on every return to the resting level, where the data path shifts. The strobes match SPI modes 0 and 2.

The period, the active-phase length and a second end-of-period bound come from three separate count fields. The polarity input picks the resting level. All four values are captured in the cycle a transfer starts, so software may rewrite them at any time without disturbing a transfer already in progress. When run is low, SCK sits at the level chosen by the live polarity input and no strobes appear. With the usual programming (period count = bound count = n, active count = (n+1)/2 − 1) the result is a clock with a near-even duty cycle and a frequency of the system rate divided by n+1.

Top module: `sck_gen`

## Requirements
- R1: While reset is asserted and in the first cycle after it, SCK equals the polarity input and both strobes are low.
- R2: While run is low, SCK equals the live polarity input (0 rests low, 1 rests high) and both strobes stay low.
- R3: A transfer begins in the cycle after run is first sampled high; an internal count starts at 0 and steps by one per cycle up to the terminal count T, then returns to 0, so SCK repeats every T+1 cycles.
- R4: While running, SCK is at the active level (the inverse of the captured polarity) when the count is at most the captured active count H, and at the resting level for counts H+1 to T.
- R5: The sample strobe is high for exactly the cycles in which SCK enters the active level, which includes the first cycle of every transfer.
- R6: The shift strobe is high for exactly the cycles in which a running SCK returns to the resting level at count H+1.
- R7: The count fields and polarity are captured only in the first cycle of a transfer; changes while run stays high have no effect until run goes low and high again.
- R8: The terminal count T is the smaller of the period field and the bound field.
- R9: A terminal count of 0 is treated as 1, giving a two-cycle period.
- R10: When H is at least T, SCK stays at the active level for the whole transfer, with one sample strobe at the start and no shift strobe.
- R11: When run drops, SCK is back at the resting level in the next cycle and no shift strobe is issued for that return.
- R12: The sample and shift strobes are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| run_i | input | 1 | High while the transfer engine wants clock pulses |
| cpol_i | input | 1 | Resting level of SCK (0 low, 1 high) |
| period_cnt_i | input | CNT_W | Period field: terminal count candidate |
| active_cnt_i | input | CNT_W | Last count of the active phase |
| bound_cnt_i | input | CNT_W | Second terminal count candidate |
| sck_o | output | 1 | Serial clock |
| sample_o | output | 1 | One-cycle strobe on entry to the active level |
| shift_o | output | 1 | One-cycle strobe on return to the resting level |

## Verification
On every cycle the embedded properties check that the count never passes the captured terminal, that it returns to zero after reaching it, that the captured configuration holds still between starts, that a start always produces a sample strobe, that run low stops the counter, and that the two strobes never coincide. Whether the waveform has the right duty cycle, the right period for a given choice between the two terminal candidates, the clamp of a zero terminal, and that a rewrite mid-transfer is ignored can only be shown by the bench, which replays each case against a behavioural model cycle by cycle and then counts strobes per transfer against closed-form totals.

// File: rtl/sck_gen_pkg.sv
package sck_gen_pkg;
    // Default width of every count field.
    localparam int SCK_CNT_W_DEF = 6;

    // Strobe pair handed from the edge marker to the top.
    typedef struct packed {
        logic sample;
        logic shift;
    } sck_strobe_t;
endpackage

// File: rtl/sck_cfg_hold.sv
module sck_cfg_hold #(
    parameter int CNT_W = sck_gen_pkg::SCK_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             start_i,
    input  logic             cpol_i,
    input  logic [CNT_W-1:0] period_cnt_i,
    input  logic [CNT_W-1:0] active_cnt_i,
    input  logic [CNT_W-1:0] bound_cnt_i,
    output logic [CNT_W-1:0] term_o,
    output logic [CNT_W-1:0] active_o,
    output logic             pol_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic [CNT_W-1:0] term;
        logic [CNT_W-1:0] active;
        logic             pol;
    } cfg_t;

    cfg_t             cfg_d, cfg_q;
    logic [CNT_W-1:0] shorter;

    always_comb begin
        cfg_d   = cfg_q;
        shorter = (bound_cnt_i < period_cnt_i) ? bound_cnt_i : period_cnt_i;
        if (start_i) begin
            cfg_d.term   = (shorter == '0) ? ONE : shorter;
            cfg_d.active = active_cnt_i;
            cfg_d.pol    = cpol_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q.term   <= ONE;
            cfg_q.active <= '0;
            cfg_q.pol    <= 1'b0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign term_o   = cfg_q.term;
    assign active_o = cfg_q.active;
    assign pol_o    = cfg_q.pol;

    // Captured values move only on a start.
    assert_cfg_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !start_i |=> ($stable(term_o) && $stable(active_o) && $stable(pol_o)));

    // The terminal count is never zero.
    assert_term_nonzero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        term_o != '0);
endmodule

// File: rtl/sck_phase_counter.sv
module sck_phase_counter #(
    parameter int CNT_W = sck_gen_pkg::SCK_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             start_i,
    input  logic [CNT_W-1:0] term_i,
    input  logic [CNT_W-1:0] active_i,
    output logic             busy_o,
    output logic [CNT_W-1:0] cnt_o,
    output logic             lead_o
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic             lead;
    } ctr_t;

    ctr_t ctr_d, ctr_q;

    always_comb begin
        ctr_d = ctr_q;
        if (!run_i) begin
            ctr_d = '0;
        end else if (start_i) begin
            ctr_d.busy = 1'b1;
            ctr_d.cnt  = '0;
            ctr_d.lead = 1'b1;
        end else begin
            ctr_d.cnt  = (ctr_q.cnt == term_i) ? '0 : ctr_q.cnt + ONE;
            ctr_d.lead = (ctr_d.cnt <= active_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctr_q <= '0;
        end else begin
            ctr_q <= ctr_d;
        end
    end

    assign busy_o = ctr_q.busy;
    assign cnt_o  = ctr_q.cnt;
    assign lead_o = ctr_q.lead;

    assert_cnt_bound_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (cnt_o <= term_i));

    assert_cnt_wrap_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && run_i && cnt_o == term_i) |=> (cnt_o == '0));

    assert_run_stop_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (!busy_o && !lead_o));

    assert_lead_span_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        busy_o |-> (lead_o == (cnt_o <= active_i)));
endmodule

// File: rtl/sck_edge_mark.sv
module sck_edge_mark (
    input  logic                     clk_i,
    input  logic                     rst_ni,
    input  logic                     busy_i,
    input  logic                     lead_i,
    input  logic                     pol_i,
    input  logic                     cpol_i,
    output logic                     sck_o,
    output sck_gen_pkg::sck_strobe_t strobe_o
);
    typedef struct packed {
        logic lead_prev;
    } edge_t;

    edge_t edge_d, edge_q;

    always_comb begin
        edge_d           = edge_q;
        edge_d.lead_prev = lead_i;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            edge_q <= '0;
        end else begin
            edge_q <= edge_d;
        end
    end

    always_comb begin
        sck_o           = busy_i ? (pol_i ^ lead_i) : cpol_i;
        strobe_o.sample = lead_i & ~edge_q.lead_prev;
        strobe_o.shift  = busy_i & ~lead_i & edge_q.lead_prev;
    end

    assert_strobe_excl_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(strobe_o.sample && strobe_o.shift));

    assert_idle_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_i |-> !strobe_o.shift);
endmodule

// File: rtl/sck_gen.sv
module sck_gen #(
    parameter int CNT_W = sck_gen_pkg::SCK_CNT_W_DEF
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             cpol_i,
    input  logic [CNT_W-1:0] period_cnt_i,
    input  logic [CNT_W-1:0] active_cnt_i,
    input  logic [CNT_W-1:0] bound_cnt_i,
    output logic             sck_o,
    output logic             sample_o,
    output logic             shift_o
);
    logic                     busy;
    logic                     lead;
    logic                     start;
    logic                     pol_held;
    logic [CNT_W-1:0]         term_held;
    logic [CNT_W-1:0]         active_held;
    logic [CNT_W-1:0]         cnt;
    sck_gen_pkg::sck_strobe_t strobe;

    assign start = run_i & ~busy;

    sck_cfg_hold #(.CNT_W(CNT_W)) u_cfg (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .start_i      (start),
        .cpol_i       (cpol_i),
        .period_cnt_i (period_cnt_i),
        .active_cnt_i (active_cnt_i),
        .bound_cnt_i  (bound_cnt_i),
        .term_o       (term_held),
        .active_o     (active_held),
        .pol_o        (pol_held)
    );

    sck_phase_counter #(.CNT_W(CNT_W)) u_ctr (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .run_i    (run_i),
        .start_i  (start),
        .term_i   (term_held),
        .active_i (active_held),
        .busy_o   (busy),
        .cnt_o    (cnt),
        .lead_o   (lead)
    );

    sck_edge_mark u_edge (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .busy_i   (busy),
        .lead_i   (lead),
        .pol_i    (pol_held),
        .cpol_i   (cpol_i),
        .sck_o    (sck_o),
        .strobe_o (strobe)
    );

    assign sample_o = strobe.sample;
    assign shift_o  = strobe.shift;

    // A start always opens with a sample strobe.
    assert_start_sample_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> sample_o);

    // The first cycle of a transfer begins at count zero.
    assert_start_zero_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        start |=> (busy && cnt == '0));
endmodule

// File: tb/sck_gen_bench.sv
module sck_gen_bench;
    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic       run_i = 1'b0;
    logic       cpol_i = 1'b0;
    logic [5:0] period_cnt_i = 6'd3;
    logic [5:0] active_cnt_i = 6'd1;
    logic [5:0] bound_cnt_i = 6'd3;
    logic       sck_o, sample_o, shift_o;

    int n_cmp = 0;
    int n_bad = 0;
    int n_sample = 0;
    int n_shift = 0;
    int n_both = 0;

    // behavioural reference state
    bit m_run = 0;
    bit m_ph = 0;
    bit m_prev = 0;
    bit m_pol = 0;
    int m_k = 0;
    int m_t = 1;
    int m_h = 0;

    always #10 clk_i = ~clk_i;

    sck_gen #(.CNT_W(6)) u_sck_gen (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .run_i        (run_i),
        .cpol_i       (cpol_i),
        .period_cnt_i (period_cnt_i),
        .active_cnt_i (active_cnt_i),
        .bound_cnt_i  (bound_cnt_i),
        .sck_o        (sck_o),
        .sample_o     (sample_o),
        .shift_o      (shift_o)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Reference model advances on each rising edge using the inputs it sees.
    always @(posedge clk_i) begin
        if (!rst_ni) begin
            m_run = 0; m_k = 0; m_ph = 0; m_prev = 0;
        end else begin
            m_prev = m_ph;
            if (!run_i) begin
                m_run = 0; m_k = 0;
            end else if (!m_run) begin
                int t;
                m_run = 1; m_k = 0;
                t = (int'(bound_cnt_i) < int'(period_cnt_i)) ? int'(bound_cnt_i) : int'(period_cnt_i);
                m_t = (t == 0) ? 1 : t;
                m_h = int'(active_cnt_i);
                m_pol = cpol_i;
            end else begin
                m_k = (m_k == m_t) ? 0 : m_k + 1;
            end
            m_ph = m_run && (m_k <= m_h);
        end
    end

    // Cycle comparison away from the active edge.
    always @(negedge clk_i) begin
        bit e_sck, e_smp, e_shf;
        string tg;
        e_sck = m_run ? (m_pol ^ m_ph) : cpol_i;
        e_smp = m_ph && !m_prev;
        e_shf = m_run && !m_ph && m_prev;
        tg = !rst_ni ? "R1" : (!m_run ? "R2" : "R4");
        check({tg, " sck"}, int'(sck_o), int'(e_sck));
        check(!rst_ni ? "R1 sample" : "R5 sample", int'(sample_o), int'(e_smp));
        check(!rst_ni ? "R1 shift" : "R6 shift", int'(shift_o), int'(e_shf));
        if (sample_o) n_sample++;
        if (shift_o) n_shift++;
        if (sample_o && shift_o) n_both++;
    end

    function automatic int exp_samples(int n, int t, int h);
        if (h >= t) return 1;
        return (n + t) / (t + 1);
    endfunction

    function automatic int exp_shifts(int n, int t, int h);
        if (h >= t) return 0;
        return n / (t + 1) + (((n % (t + 1)) > h + 1) ? 1 : 0);
    endfunction

    task automatic set_cfg(input int p, input int a, input int b, input bit pol);
        period_cnt_i = 6'(p);
        active_cnt_i = 6'(a);
        bound_cnt_i  = 6'(b);
        cpol_i       = pol;
    endtask

    // Runs a transfer of n active cycles and checks strobe totals.
    task automatic burst(input string tag, input int n, input int t, input int h);
        @(posedge clk_i); #3;
        n_sample = 0; n_shift = 0;
        run_i = 1'b1;
        repeat (n) @(posedge clk_i);
        #3 run_i = 1'b0;
        repeat (3) @(posedge clk_i);
        #3;
        check({tag, " sample count"}, n_sample, exp_samples(n, t, h));
        check({tag, " shift count"}, n_shift, exp_shifts(n, t, h));
    endtask

    initial begin
        #(20 * 200000);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(posedge clk_i);
        #3 rst_ni = 1'b1;
        @(negedge clk_i);
        check("R1 sck after reset", int'(sck_o), 0);
        check("R1 sample after reset", int'(sample_o), 0);

        // R2: idle level follows live polarity
        @(posedge clk_i); #3 cpol_i = 1'b1;
        @(negedge clk_i);
        check("R2 idle high", int'(sck_o), 1);
        @(posedge clk_i); #3 cpol_i = 1'b0;
        @(negedge clk_i);
        check("R2 idle low", int'(sck_o), 0);

        // R3 R4 R5 R6: conventional n=3
        set_cfg(3, 1, 3, 1'b0);
        burst("R3 n3", 20, 3, 1);
        // n=4 with polarity 1
        set_cfg(4, 1, 4, 1'b1);
        burst("R4 n4 pol1", 17, 4, 1);
        // R8: bound shorter than period
        set_cfg(9, 1, 3, 1'b0);
        burst("R8 bound", 16, 3, 1);
        // R9: zero terminal
        set_cfg(0, 0, 0, 1'b0);
        burst("R9 zero", 10, 1, 0);
        // R10: active count covers the period
        set_cfg(5, 7, 5, 1'b1);
        burst("R10 long lead", 12, 5, 7);
        // large divider
        set_cfg(63, 31, 63, 1'b0);
        burst("R3 n63", 130, 63, 31);

        // R7: rewrite while running is ignored
        set_cfg(3, 1, 3, 1'b0);
        @(posedge clk_i); #3;
        n_sample = 0; n_shift = 0;
        run_i = 1'b1;
        repeat (2) @(posedge clk_i);
        #3 set_cfg(7, 3, 7, 1'b1);
        repeat (14) @(posedge clk_i);
        #3 run_i = 1'b0;
        repeat (3) @(posedge clk_i);
        #3;
        check("R7 old cfg samples", n_sample, exp_samples(16, 3, 1));
        check("R7 old cfg shifts", n_shift, exp_shifts(16, 3, 1));
        burst("R7 new cfg", 16, 7, 3);

        // R11: stop inside the active phase
        set_cfg(5, 2, 5, 1'b0);
        @(posedge clk_i); #3;
        n_sample = 0; n_shift = 0;
        run_i = 1'b1;
        repeat (2) @(posedge clk_i);
        #3 run_i = 1'b0;
        @(negedge clk_i);
        check("R11 sck high before stop edge", int'(sck_o), 1);
        @(negedge clk_i);
        check("R11 sck idle after stop", int'(sck_o), 0);
        check("R11 no shift on stop", int'(shift_o), 0);
        repeat (2) @(posedge clk_i);
        #3;
        check("R11 shift total", n_shift, 0);
        check("R11 sample total", n_sample, 1);

        // R12: strobes never coincide
        check("R12 coincident strobes", n_both, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule